// File: doc/BRIEF.md
# Sideband Interrupt Holding Latch with Wake Request

This block sits between the sideband interrupt pins of a processor core and its power controller. While the core is in any clock-stopped state, it catches rising edges on the system-management, init and two local interrupt lines, plus a monitor-event strobe. It holds each one in a single pending bit. Whenever anything is held, it pulls an active-low break-event line low so that system logic brings the core back to its running state. The interrupt-enable flag has no influence on that line.

When the power controller reports the running state again, each held source raises its own service request. The request stays up until the core acknowledges it. The acknowledge clears the bit. Repeated arrivals of one source during the low-power period therefore produce exactly one request.

The two local interrupt lines are maskable. Their requests are held back while the interrupt-enable flag is clear. The system-management and init requests are never gated. Prioritising between sources and delivering vectors are left to the logic downstream.

Top module: `wake_latch_top`

## Requirements
- R1: In the cycle after synchronous reset, `brk_evt_n` is 1 and `svc_req` is all zero.
- R2: A rising edge on `src_lvl[i]` sets that source's pending bit when it is seen at a clock edge where `pwr_state` is not 2'b00. Bit order is [0] system-management, [1] init, [2] local line 0, [3] local line 1. The codes are 2'b00 running, 2'b01 stop-granted, 2'b10 snoop, 2'b11 deep.
- R3: Rising edges on `src_lvl` and pulses on `mon_evt` seen while `pwr_state` is 2'b00 are not latched.
- R4: Any number of edges of one source during a low-power period yield a single service request, and one acknowledge retires it.
- R5: `svc_req[i]` is high when bit i is pending and `pwr_state` was 2'b00 at the previous edge. For bits 2 and 3 this also requires `intr_en` = 1; bits 0 and 1 ignore `intr_en`.
- R6: A pending bit clears at the clock edge where both `svc_req[i]` and `svc_ack[i]` are high, unless a new edge sets it again at that same edge.
- R7: `brk_evt_n` goes low one cycle after any source or monitor event becomes pending, whatever the value of `intr_en`.
- R8: `brk_evt_n` returns high one cycle after every pending bit and the monitor flag are clear.
- R9: A `mon_evt` pulse during low power sets a monitor flag. The flag drives the break event and clears at the first edge where `pwr_state` is 2'b00; it never raises a service request.
- R10: A source level held high across the return to running causes no second request after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Sideband interrupt levels, order per R2 |
| mon_evt | input | 1 | Monitor-event strobe |
| intr_en | input | 1 | Interrupt-enable flag, gates maskable requests only |
| pwr_state | input | 2 | Power state from the controller, 2'b00 = running |
| svc_ack | input | NSRC | Per-source acknowledge from the core |
| svc_req | output | NSRC | Per-source service request |
| brk_evt_n | output | 1 | Active-low break event |

## Verification
The assertions check on every cycle that:
- requests appear only after a running-state edge and maskable requests stay low while the enable is clear;
- an acknowledged request drops;
- nothing is latched in the running state;
- the break line follows the held state with one cycle of lag.

Only the bench's scenarios can show the following:
- collapsing several arrivals into one service;
- a held level across the transition causing no repeat;
- the monitor flag clearing on return to running.

These are shown against a cycle-level reference model, under directed and random stimulus.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'b00,
    PS_GRANT = 2'b01,
    PS_SNOOP = 2'b10,
    PS_DEEP  = 2'b11
  } pwr_state_e;

  localparam int SRC_SMI   = 0;
  localparam int SRC_INIT  = 1;
  localparam int SRC_LOC0  = 2;
  localparam int SRC_LOC1  = 3;
  localparam int SRC_COUNT = 4;

  function automatic logic is_running(input logic [1:0] st);
    return st == PS_RUN;
  endfunction

endpackage

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/wake_latch.sv
module wake_latch #(
  parameter int              NSRC     = 4,
  parameter logic [NSRC-1:0] MASKABLE = 4'b1100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] rise,
  input  logic            set_en,
  input  logic            in_run,
  input  logic            intr_en,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] req
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= in_run;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hold_q;
    logic gate;

    if (MASKABLE[i]) begin : g_mask
      assign gate = intr_en;
    end else begin : g_nomask
      assign gate = 1'b1;
    end

    assign req[i]  = hold_q & run_q & gate;
    assign pend[i] = hold_q;

    always_ff @(posedge clk) begin
      if (rst)                      hold_q <= 1'b0;
      else if (set_en && rise[i])   hold_q <= 1'b1;
      else if (req[i] && ack[i])    hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_brk.sv
module wake_brk #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mon_evt,
  input  logic            in_run,
  input  logic [NSRC-1:0] pend,
  output logic            mon_q,
  output logic            brk_n
);
  always_ff @(posedge clk) begin
    if (rst)         mon_q <= 1'b0;
    else if (in_run) mon_q <= 1'b0;
    else if (mon_evt) mon_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) brk_n <= 1'b1;
    else     brk_n <= ~((|pend) | mon_q);
  end
endmodule

// File: rtl/wake_latch_top.sv
module wake_latch_top
  import wake_pkg::*;
#(
  parameter int              NSRC     = SRC_COUNT,
  parameter logic [NSRC-1:0] MASKABLE = 4'b1100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            mon_evt,
  input  logic            intr_en,
  input  logic [1:0]      pwr_state,
  input  logic [NSRC-1:0] svc_ack,
  output logic [NSRC-1:0] svc_req,
  output logic            brk_evt_n
);
  logic            in_run;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] pend;
  logic            mon_pend;

  assign in_run = is_running(pwr_state);

  wake_edge #(.W(NSRC)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (src_lvl),
    .rise(rise)
  );

  wake_latch #(.NSRC(NSRC), .MASKABLE(MASKABLE)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .rise   (rise),
    .set_en (~in_run),
    .in_run (in_run),
    .intr_en(intr_en),
    .ack    (svc_ack),
    .pend   (pend),
    .req    (svc_req)
  );

  wake_brk #(.NSRC(NSRC)) u_brk (
    .clk    (clk),
    .rst    (rst),
    .mon_evt(mon_evt),
    .in_run (in_run),
    .pend   (pend),
    .mon_q  (mon_pend),
    .brk_n  (brk_evt_n)
  );
endmodule

// File: rtl/wake_chk.sv
module wake_chk #(
  parameter int              NSRC     = 4,
  parameter logic [NSRC-1:0] MASKABLE = 4'b1100
) (
  input logic            clk,
  input logic            rst,
  input logic            intr_en,
  input logic [1:0]      pwr_state,
  input logic [NSRC-1:0] svc_ack,
  input logic [NSRC-1:0] svc_req,
  input logic            brk_evt_n,
  input logic [NSRC-1:0] pend_w,
  input logic            mon_w
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    // R1
    if (rst_d && !rst) begin
      reset_state_chk: assert (brk_evt_n && svc_req == '0);
    end
  end

  // R5
  req_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_req != '0) |-> $past(pwr_state == 2'b00));

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !intr_en |-> ((svc_req & MASKABLE) == '0));

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((svc_req & svc_ack) != '0) |=> ((svc_req & $past(svc_req & svc_ack)) == '0));

  // R3
  no_set_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00) |=> ((pend_w & ~$past(pend_w)) == '0));

  // R7
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_w != '0) || mon_w) |=> !brk_evt_n);

  // R8
  brk_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_w == '0) && !mon_w) |=> brk_evt_n);
endmodule

bind wake_latch_top wake_chk #(.NSRC(NSRC), .MASKABLE(MASKABLE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .intr_en  (intr_en),
  .pwr_state(pwr_state),
  .svc_ack  (svc_ack),
  .svc_req  (svc_req),
  .brk_evt_n(brk_evt_n),
  .pend_w   (pend),
  .mon_w    (mon_pend)
);

// File: tb/wake_latch_top_test.sv
`timescale 1ns/1ps
module wake_latch_top_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0;
  logic         mon = 1'b0;
  logic         ien = 1'b0;
  logic [1:0]   pst = 2'b00;
  logic [N-1:0] ack = '0;
  logic [N-1:0] svc_req;
  logic         brk_evt_n;

  always #2.5 clk = ~clk;

  wake_latch_top uut (
    .clk(clk), .rst(rst), .src_lvl(src), .mon_evt(mon), .intr_en(ien),
    .pwr_state(pst), .svc_ack(ack), .svc_req(svc_req), .brk_evt_n(brk_evt_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    live = 1'b0;
  bit    done = 1'b0;

  bit m_prev[N];
  bit m_pend[N];
  bit m_run, m_mon, m_brk;

  function automatic logic [N-1:0] model_req();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_pend[i] && m_run && (i < 2 || ien);
    return r;
  endfunction

  always @(posedge clk) begin : model
    bit anyp;
    bit rq;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_prev[i] <= 0; m_pend[i] <= 0; end
      m_run <= 0; m_mon <= 0; m_brk <= 1;
    end else begin
      anyp = m_mon;
      for (int i = 0; i < N; i++) begin
        rq = m_pend[i] && m_run && (i < 2 || ien);
        anyp = anyp | m_pend[i];
        if (pst != 2'b00 && src[i] && !m_prev[i]) m_pend[i] <= 1;
        else if (rq && ack[i])                    m_pend[i] <= 0;
        m_prev[i] <= src[i];
      end
      m_run <= (pst == 2'b00);
      m_mon <= (pst == 2'b00) ? 1'b0 : (m_mon | mon);
      m_brk <= !anyp;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      n_cmp++;
      if (svc_req !== model_req()) begin
        n_bad++;
        $display("FAIL %s svc_req actual=%b expected=%b", tag, svc_req, model_req());
      end
      n_cmp++;
      if (brk_evt_n !== m_brk) begin
        n_bad++;
        $display("FAIL %s brk_evt_n actual=%b expected=%b", tag, brk_evt_n, m_brk);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_eq(input string rq, input logic [N-1:0] req_e, input logic brk_e);
    @(negedge clk); #0.1;
    n_cmp++;
    if (svc_req !== req_e || brk_evt_n !== brk_e) begin
      n_bad++;
      $display("FAIL %s actual req=%b brk=%b expected req=%b brk=%b",
               rq, svc_req, brk_evt_n, req_e, brk_e);
    end
    @(posedge clk); #1;
  endtask

  task automatic pulse_src(input int i);
    src[i] = 1'b1; step(1); src[i] = 1'b0; step(1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    live = 1'b1;
    expect_eq("R1", 4'b0000, 1'b1);

    // R2 R4 R7: several edges of one source, masked local line, monitor
    tag = "R2";
    pst = 2'b01; ien = 1'b0; step(2);
    pulse_src(0); pulse_src(0); pulse_src(0);
    pulse_src(2);
    mon = 1'b1; step(1); mon = 1'b0; step(2);
    tag = "R7";
    expect_eq("R7", 4'b0000, 1'b0);
    pst = 2'b00; step(2);
    tag = "R5";
    expect_eq("R5", 4'b0001, 1'b0);
    ien = 1'b1; step(1);
    expect_eq("R5", 4'b0101, 1'b0);
    tag = "R6";
    ack = 4'b0001; step(1); ack = '0; step(2);
    expect_eq("R4", 4'b0100, 1'b0);
    ack = 4'b0100; step(1); ack = '0; step(2);
    tag = "R8";
    expect_eq("R8", 4'b0000, 1'b1);

    // R3: edges and monitor pulses in running state
    tag = "R3";
    pulse_src(1); pulse_src(3);
    mon = 1'b1; step(1); mon = 1'b0; step(3);
    expect_eq("R3", 4'b0000, 1'b1);

    // R10: level held across return to running
    tag = "R10";
    pst = 2'b01; src[3] = 1'b1; step(3);
    pst = 2'b00; step(2);
    expect_eq("R10", 4'b1000, 1'b0);
    ack = 4'b1000; step(1); ack = '0; step(3);
    expect_eq("R10", 4'b0000, 1'b1);
    src[3] = 1'b0; step(2);

    // R9: monitor event alone
    tag = "R9";
    pst = 2'b10; mon = 1'b1; step(1); mon = 1'b0; step(2);
    expect_eq("R9", 4'b0000, 1'b0);
    pst = 2'b00; step(3);
    expect_eq("R9", 4'b0000, 1'b1);

    // R6 with deep state and an init source, never masked
    tag = "R6";
    ien = 1'b0; pst = 2'b11; pulse_src(1);
    pst = 2'b00; step(2);
    expect_eq("R6", 4'b0010, 1'b0);
    ack = 4'b0010; step(1); ack = '0; step(2);
    expect_eq("R6", 4'b0000, 1'b1);

    // Random stimulus against the model
    tag = "R2";
    for (int k = 0; k < 2000; k++) begin
      pst = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : pst;
      if ($urandom_range(0, 5) == 0) pst = 2'b00;
      src = N'($urandom);
      mon = ($urandom_range(0, 7) == 0);
      ien = ($urandom_range(0, 3) != 0);
      ack = N'($urandom);
      step(1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s watchdog actual=running expected=finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule